// File: doc/BRIEF.md
# Four-Mode Mantissa Rounding Unit

This block is the rounding stage of a floating-point datapath. It takes an extended mantissa and the sign of the value. The two lowest bits of the mantissa are the guard bit (bit 1) and the round bit (bit 0). A separate sticky bit carries the OR of every bit shifted out earlier. The block removes the guard and round positions and decides, from the selected rounding direction, whether to add one unit in the last place of the remaining mantissa. The increment is built as a chain of word-sized adders, so the carry ripples through a mantissa of any width.

The result is registered: one cycle after a valid request, the block presents the rounded mantissa and a separate carry-out. It also raises a rounded-up flag and two status flags. One status flag reports any loss of precision. The other reports that the fraction was actually incremented. The block does not normalise a carry-out (a mantissa that became 2.0), adjust exponents or pack results. The consumer uses `carry_out` and `rounded_up` to do that.

Top module: `rnd_unit`

## Requirements
- R1: With `rst` high at a clock edge, every output is zero after that edge.
- R2: A request with `in_valid` high produces its result one clock later, with `out_valid` high for that one cycle. While `in_valid` is low, `mant_out`, `carry_out` and all flags keep their previous values and `out_valid` is low.
- R3: If guard (`mant_in[1]`), round (`mant_in[0]`) and `sticky_in` are all zero, `mant_out` equals `mant_in` shifted right by two. No flag is set and `carry_out` is zero.
- R4: If any of guard, round or sticky is one, both `inexact` and `frac_inexact` are set.
- R5: In mode 2'b00 (nearest), the increment is applied only when guard is one and at least one of these is one: round, sticky, or bit 0 of the shifted mantissa. A tie therefore rounds to an even result.
- R6: In mode 2'b01 (toward zero), the mantissa is never incremented.
- R7: In mode 2'b10 (toward plus infinity), an inexact value is incremented only when `sign_in` is 0.
- R8: In mode 2'b11 (toward minus infinity), an inexact value is incremented only when `sign_in` is 1.
- R9: `rounded_up` and `frac_rounded` are both set exactly when the increment was applied. Neither is ever set without `inexact`.
- R10: The increment carries across every internal word boundary. An all-ones shifted mantissa that is incremented gives `mant_out` zero and `carry_out` one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mant_in | input | MANT_W | Extended mantissa; bit 1 guard, bit 0 round |
| sticky_in | input | 1 | OR of bits discarded before this stage |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| mode_in | input | 2 | Rounding direction: 00 nearest, 01 zero, 10 plus inf, 11 minus inf |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| mant_out | output | MANT_W-2 | Rounded mantissa |
| carry_out | output | 1 | Carry out of the top of the increment |
| rounded_up | output | 1 | Increment was applied |
| inexact | output | 1 | Precision was lost |
| frac_inexact | output | 1 | Fraction inexact status |
| frac_rounded | output | 1 | Fraction was incremented |

## Verification
The stimulus walks each mode through these patterns:
- guard/round/sticky all clear, which separates the exact path from the inexact path;
- round or sticky alone, which shows that nearest mode needs the guard bit;
- an exact tie on even and odd mantissas, which exposes ties-to-even;
- the same inexact pattern with both signs, which separates the two directed modes from each other and from truncation.

Mantissas ending in 0xFF, 0xFFFFFF and all ones test the carry at each word boundary and the wrap into `carry_out`. Directed steps check the reset state and that results hold while no request is presented.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS     = 2'b10,
        RM_NEG     = 2'b11
    } rmode_e;

    // bits that lie below the kept mantissa
    typedef struct packed {
        logic guard;
        logic rbit;
        logic sticky;
    } grs_t;

    typedef struct packed {
        logic inc;
        logic lost;
    } rnd_decision_t;

    function automatic logic any_lost(grs_t b);
        return b.guard | b.rbit | b.sticky;
    endfunction

    // increment decision for one value; lsb is bit 0 after the shift
    function automatic rnd_decision_t decide(rmode_e m, grs_t b,
                                             logic neg, logic lsb);
        rnd_decision_t d;
        d.lost = any_lost(b);
        d.inc  = 1'b0;
        if (d.lost) begin
            unique case (m)
                RM_NEAREST: d.inc = b.guard & (b.rbit | b.sticky | lsb);
                RM_ZERO:    d.inc = 1'b0;
                RM_POS:     d.inc = ~neg;
                RM_NEG:     d.inc = neg;
                default:    d.inc = 1'b0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/rnd_split.sv
module rnd_split #(
    parameter int MANT_W = 34
) (
    input  logic              [MANT_W-1:0] mant,
    input  logic                           sticky,
    output logic              [MANT_W-3:0] body,
    output rnd_pkg::grs_t                  low
);
    always_comb begin
        body       = mant[MANT_W-1:2];
        low.guard  = mant[1];
        low.rbit   = mant[0];
        low.sticky = sticky;
    end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide (
    input  logic [1:0]            mode,
    input  rnd_pkg::grs_t         low,
    input  logic                  neg,
    input  logic                  lsb,
    output rnd_pkg::rnd_decision_t dec
);
    import rnd_pkg::*;

    always_comb begin
        dec = decide(rmode_e'(mode), low, neg, lsb);
    end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int BODY_W = 32,
    parameter int WORD_W = 8
) (
    input  logic [BODY_W-1:0] body,
    input  logic              inc,
    output logic [BODY_W-1:0] sum,
    output logic              cout
);
    localparam int NW = (BODY_W + WORD_W - 1) / WORD_W;

    logic [NW:0] chain;
    assign chain[0] = inc;

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam int LO = w * WORD_W;
        localparam int WW = (w == NW - 1) ? (BODY_W - LO) : WORD_W;
        logic [WW:0] part;
        assign part           = {1'b0, body[LO +: WW]} + (WW + 1)'(chain[w]);
        assign sum[LO +: WW]  = part[WW-1:0];
        assign chain[w+1]     = part[WW];
    end

    assign cout = chain[NW];
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit #(
    parameter int MANT_W = 34,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] mant_in,
    input  logic              sticky_in,
    input  logic              sign_in,
    input  logic [1:0]        mode_in,
    output logic              out_valid,
    output logic [MANT_W-3:0] mant_out,
    output logic              carry_out,
    output logic              rounded_up,
    output logic              inexact,
    output logic              frac_inexact,
    output logic              frac_rounded
);
    import rnd_pkg::*;

    localparam int BODY_W = MANT_W - 2;

    logic [BODY_W-1:0] body;
    logic [BODY_W-1:0] sum;
    logic              cout;
    grs_t              low;
    rnd_decision_t     dec;

    rnd_split #(.MANT_W(MANT_W)) split_i (
        .mant   (mant_in),
        .sticky (sticky_in),
        .body   (body),
        .low    (low)
    );

    rnd_decide decide_i (
        .mode (mode_in),
        .low  (low),
        .neg  (sign_in),
        .lsb  (body[0]),
        .dec  (dec)
    );

    rnd_incr #(.BODY_W(BODY_W), .WORD_W(WORD_W)) incr_i (
        .body (body),
        .inc  (dec.inc),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            mant_out     <= '0;
            carry_out    <= 1'b0;
            rounded_up   <= 1'b0;
            inexact      <= 1'b0;
            frac_inexact <= 1'b0;
            frac_rounded <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mant_out     <= sum;
                carry_out    <= cout;
                rounded_up   <= dec.inc;
                inexact      <= dec.lost;
                frac_inexact <= dec.lost;
                frac_rounded <= dec.inc;
            end
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(mant_out) && $stable(rounded_up) && !out_valid));

    // R3
    exact_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mant_in[1:0] == 2'b00 && !sticky_in)
        |=> (!inexact && !rounded_up && mant_out == $past(mant_in[MANT_W-1:2])));

    // R6
    rtz_no_up_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_in == 2'b01) |=> !rounded_up);

    // R9
    up_needs_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        rounded_up |-> inexact);

    // R10
    carry_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (mant_out == '0 && rounded_up));

endmodule

// File: tb/rnd_unit_tb_top.sv
`timescale 1ns/1ps
module rnd_unit_tb_top;

    localparam int MANT_W = 34;
    localparam int NVEC   = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [MANT_W-1:0] mant_in = '0;
    logic              sticky_in = 1'b0;
    logic              sign_in = 1'b0;
    logic [1:0]        mode_in = 2'b00;
    logic              out_valid;
    logic [MANT_W-3:0] mant_out;
    logic              carry_out, rounded_up, inexact, frac_inexact, frac_rounded;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rnd_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mant_in(mant_in),
        .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
        .out_valid(out_valid), .mant_out(mant_out), .carry_out(carry_out),
        .rounded_up(rounded_up), .inexact(inexact), .frac_inexact(frac_inexact),
        .frac_rounded(frac_rounded)
    );

    // {mode, sign, sticky, mant_in[33:0], exp_mant[31:0], exp_carry, exp_up, exp_inexact}
    localparam logic [72:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 1'b0, 32'h0000_0010, 2'b00, 32'h0000_0010, 3'b000}, // R3 exact
        {2'b00, 1'b0, 1'b0, 32'h0000_0010, 2'b01, 32'h0000_0010, 3'b001}, // R5 round bit only
        {2'b00, 1'b0, 1'b0, 32'h0000_0010, 2'b10, 32'h0000_0010, 3'b001}, // R5 tie, even
        {2'b00, 1'b0, 1'b0, 32'h0000_0011, 2'b10, 32'h0000_0012, 3'b011}, // R5 tie, odd
        {2'b00, 1'b0, 1'b1, 32'h0000_0010, 2'b10, 32'h0000_0011, 3'b011}, // R5 guard+sticky
        {2'b00, 1'b1, 1'b0, 32'h0000_0010, 2'b11, 32'h0000_0011, 3'b011}, // R5 guard+round
        {2'b00, 1'b0, 1'b1, 32'h0000_0010, 2'b00, 32'h0000_0010, 3'b001}, // R4 sticky only
        {2'b01, 1'b0, 1'b1, 32'h0000_0010, 2'b11, 32'h0000_0010, 3'b001}, // R6
        {2'b01, 1'b1, 1'b0, 32'h0000_0010, 2'b11, 32'h0000_0010, 3'b001}, // R6
        {2'b10, 1'b0, 1'b0, 32'h0000_0010, 2'b01, 32'h0000_0011, 3'b011}, // R7 positive
        {2'b10, 1'b1, 1'b0, 32'h0000_0010, 2'b11, 32'h0000_0010, 3'b001}, // R7 negative
        {2'b11, 1'b1, 1'b1, 32'h0000_0010, 2'b00, 32'h0000_0011, 3'b011}, // R8 negative
        {2'b11, 1'b0, 1'b0, 32'h0000_0010, 2'b10, 32'h0000_0010, 3'b001}, // R8 positive
        {2'b10, 1'b0, 1'b0, 32'h0000_00FF, 2'b01, 32'h0000_0100, 3'b011}, // R10 word 0
        {2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF, 2'b01, 32'h0000_0000, 3'b111}, // R10 wrap
        {2'b10, 1'b0, 1'b0, 32'h00FF_FFFF, 2'b10, 32'h0100_0000, 3'b011}, // R10 three words
        {2'b11, 1'b1, 1'b0, 32'hFFFF_FFFF, 2'b00, 32'hFFFF_FFFF, 3'b000}  // R3 exact ones
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] m, input logic s, input logic st,
                         input logic [MANT_W-1:0] mt);
        @(negedge clk);
        mode_in = m; sign_in = s; sticky_in = st; mant_in = mt; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_zero(input string req);
        check(req, {26'd0, out_valid, carry_out, rounded_up, inexact,
                    frac_inexact, frac_rounded}, 32'd0);
        check(req, mant_out, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_zero("R1 reset state");

        for (int i = 0; i < NVEC; i++) begin
            logic [72:0] v;
            v = VEC[i];
            issue(v[72:71], v[70], v[69], v[68:35]);
            check("R2 out_valid", {31'd0, out_valid}, 32'd1);
            check("R3/R5-R8/R10 mant_out", mant_out, v[34:3]);
            check("R10 carry_out", {31'd0, carry_out}, {31'd0, v[2]});
            check("R5-R8 rounded_up", {31'd0, rounded_up}, {31'd0, v[1]});
            check("R9 frac_rounded", {31'd0, frac_rounded}, {31'd0, v[1]});
            check("R4 inexact", {31'd0, inexact}, {31'd0, v[0]});
            check("R4 frac_inexact", {31'd0, frac_inexact}, {31'd0, v[0]});
        end

        // R2: results hold while no request is presented
        issue(2'b00, 1'b0, 1'b0, {32'h0000_0011, 2'b10});
        @(negedge clk);
        mode_in = 2'b10; sign_in = 1'b0; sticky_in = 1'b1;
        mant_in = {32'hFFFF_FFFF, 2'b11};
        repeat (2) @(negedge clk);
        check("R2 hold mant_out", mant_out, 32'h0000_0012);
        check("R2 hold rounded_up", {31'd0, rounded_up}, 32'd1);
        check("R2 hold carry_out", {31'd0, carry_out}, 32'd0);
        check("R2 idle out_valid", {31'd0, out_valid}, 32'd0);

        // R1: reset in mid-run clears the result
        issue(2'b10, 1'b0, 1'b0, {32'hFFFF_FFFF, 2'b01});
        check("R10 wrap before reset", {31'd0, carry_out}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_zero("R1 mid-run reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule